// File: doc/BRIEF.md
# Converter Start Trigger Selector

This block decides when a digital-to-analog conversion begins. It issues a single-clock start pulse to the conversion sequencer. When trigger mode is enabled, an encoded select picks one of eight sources: a self-clearing software trigger bit, an external pin, four timer event lines and two PWM event lines. When trigger mode is off, each write strobe to the holding-data register starts a conversion directly.

The external pin is asynchronous. It passes through a synchronizer and is then qualified by one of four conditions: low level, high level, falling edge or rising edge. The level conditions fire only while the sequencer reports that it is idle, so a held level cannot restart a conversion that is already running. The start output is registered. It is forced low while the converter enable is 0. It is never high on two cycles in a row.

Top module: `dac_start_sel`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `start_o` is 0. `sw_trig_rdata` always reads 0.
- R2: With `trig_mode_en` = 0 and `conv_en` = 1, a `data_wr` strobe sampled at a clock edge makes `start_o` high after that same edge. All trigger sources are ignored in this mode.
- R3: With `trig_mode_en` = 1, `data_wr` strobes do not affect `start_o`.
- R4: The encoding of `src_sel` is: 0 = software bit, 1 = external pin, 2 to 5 = `timer_evt[0]` to `timer_evt[3]`, 6 = `pwm_evt[0]`, 7 = `pwm_evt[1]`. A selected event sampled high at an edge drives `start_o` high after that edge. Events on unselected lines are ignored.
- R5: A `sw_trig_wr` with `sw_trig_wdata` = 1 sets the software bit for exactly one cycle, and the bit then clears itself. With source 0 selected, `start_o` rises one cycle after the write edge. A write of 0 does nothing.
- R6: The encoding of `ext_qual` is: 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. The pin goes through a two-flop synchronizer. An edge on the pin that is first sampled at edge k gives `start_o` high after edge k+2.
- R7: In the level modes, a start is issued only while `busy` is 0 at the sampling edge.
- R8: `start_o` is never high on two consecutive cycles, even when the source stays asserted.
- R9: While `conv_en` is 0 at a sampling edge, `start_o` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Converter enable; gates all starts |
| trig_mode_en | input | 1 | 1 = selected source triggers; 0 = data writes trigger |
| src_sel | input | 3 | Trigger source select |
| ext_qual | input | 2 | External pin qualification |
| sw_trig_wr | input | 1 | Write strobe for the software trigger bit |
| sw_trig_wdata | input | 1 | Value written to the software trigger bit |
| sw_trig_rdata | output | 1 | Read-back of the software trigger bit (always 0) |
| data_wr | input | 1 | Holding-data register write strobe |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| timer_evt | input | 4 | Timer event pulses |
| pwm_evt | input | 2 | PWM event pulses |
| busy | input | 1 | Sequencer conversion-in-progress flag |
| start_o | output | 1 | Registered single-cycle conversion start |

## Verification
The assertions assume that every input except `ext_pin` is synchronous to `clk` and stable around the rising edge. They also assume that `src_sel` and `ext_qual` are the values in effect at the edge being checked, because the implications sample them in that same cycle. The bench changes every input, the pin included, only on the falling edge. It holds the pin steady for several cycles during the directed edge checks. This lets the synchronizer latency and the exact start cycle be predicted.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;

  typedef enum logic [1:0] {
    QUAL_LOW  = 2'd0,
    QUAL_HIGH = 2'd1,
    QUAL_FALL = 2'd2,
    QUAL_RISE = 2'd3
  } qual_e;

  localparam int SRC_SOFT     = 0;
  localparam int SRC_PIN      = 1;
  localparam int SRC_TMR_BASE = 2;

endpackage

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dac_ext_qual.sv
module dac_ext_qual
  import dac_trig_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_s,
  input  qual_e mode,
  input  logic  busy,
  output logic  hit
);
  logic pin_d;

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b0;
    else     pin_d <= pin_s;
  end

  always_comb begin
    unique case (mode)
      QUAL_LOW:  hit = ~pin_s & ~busy;
      QUAL_HIGH: hit =  pin_s & ~busy;
      QUAL_FALL: hit = ~pin_s &  pin_d;
      QUAL_RISE: hit =  pin_s & ~pin_d;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dac_swtrg_bit.sv
module dac_swtrg_bit (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wdata,
  output logic pulse,
  output logic rdata
);
  logic bit_q;

  // A write of 1 sets the bit; with no new write it falls back to 0 on the next edge.
  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= wr & wdata;
  end

  assign pulse = bit_q;
  assign rdata = 1'b0;
endmodule

// File: rtl/dac_start_sel.sv
module dac_start_sel
  import dac_trig_pkg::*;
#(
  parameter int NUM_TIMERS  = 4,
  parameter int NUM_PWM     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_SRC    = SRC_TMR_BASE + NUM_TIMERS + NUM_PWM,
  localparam int SEL_W      = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  conv_en,
  input  logic                  trig_mode_en,
  input  logic [SEL_W-1:0]      src_sel,
  input  logic [1:0]            ext_qual,
  input  logic                  sw_trig_wr,
  input  logic                  sw_trig_wdata,
  output logic                  sw_trig_rdata,
  input  logic                  data_wr,
  input  logic                  ext_pin,
  input  logic [NUM_TIMERS-1:0] timer_evt,
  input  logic [NUM_PWM-1:0]    pwm_evt,
  input  logic                  busy,
  output logic                  start_o
);
  localparam int SEL_SPAN = 1 << SEL_W;
  localparam int PWM_BASE = SRC_TMR_BASE + NUM_TIMERS;

  logic                pin_s;
  logic                ext_hit;
  logic                sw_pulse;
  logic [NUM_SRC-1:0]  src_vec;
  logic [SEL_SPAN-1:0] src_pad;
  logic                sel_hit;
  logic                cand;
  logic                start_q;

  dac_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_pin),
    .q   (pin_s)
  );

  dac_ext_qual u_qual (
    .clk   (clk),
    .rst   (rst),
    .pin_s (pin_s),
    .mode  (qual_e'(ext_qual)),
    .busy  (busy),
    .hit   (ext_hit)
  );

  dac_swtrg_bit u_sw (
    .clk   (clk),
    .rst   (rst),
    .wr    (sw_trig_wr),
    .wdata (sw_trig_wdata),
    .pulse (sw_pulse),
    .rdata (sw_trig_rdata)
  );

  assign src_vec[SRC_SOFT] = sw_pulse;
  assign src_vec[SRC_PIN]  = ext_hit;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    assign src_vec[SRC_TMR_BASE + t] = timer_evt[t];
  end

  for (genvar p = 0; p < NUM_PWM; p++) begin : g_pwm
    assign src_vec[PWM_BASE + p] = pwm_evt[p];
  end

  // Codes beyond the last source read as a zero line.
  assign src_pad = SEL_SPAN'(src_vec);
  assign sel_hit = src_pad[src_sel];
  assign cand    = trig_mode_en ? sel_hit : data_wr;

  // Registered start; its own feedback keeps it one clock wide.
  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= conv_en & cand & ~start_q;
  end

  assign start_o = start_q;
endmodule

// File: rtl/dac_start_sel_chk.sv
module dac_start_sel_chk #(
  parameter int NUM_TIMERS = 4,
  parameter int NUM_PWM    = 2,
  parameter int SEL_W      = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  conv_en,
  input logic                  trig_mode_en,
  input logic [SEL_W-1:0]      src_sel,
  input logic                  data_wr,
  input logic [NUM_TIMERS-1:0] timer_evt,
  input logic [NUM_PWM-1:0]    pwm_evt,
  input logic                  start_o
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !start_o)
    else $error("start high after reset cycle");

  p_direct_write_r2: assert property (@(posedge clk) disable iff (rst)
    (!trig_mode_en && data_wr && conv_en && !start_o) |=> start_o)
    else $error("data write did not start");

  p_timer0_start_r4: assert property (@(posedge clk) disable iff (rst)
    (trig_mode_en && src_sel == SEL_W'(2) && timer_evt[0] && conv_en && !start_o) |=> start_o)
    else $error("selected timer event did not start");

  p_pwm1_start_r4: assert property (@(posedge clk) disable iff (rst)
    (trig_mode_en && src_sel == SEL_W'(7) && pwm_evt[NUM_PWM-1] && conv_en && !start_o) |=> start_o)
    else $error("selected pwm event did not start");

  p_one_wide_r8: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o)
    else $error("start wider than one clock");

  p_enable_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !conv_en |=> !start_o)
    else $error("start while converter disabled");
endmodule

bind dac_start_sel dac_start_sel_chk #(
  .NUM_TIMERS (NUM_TIMERS),
  .NUM_PWM    (NUM_PWM),
  .SEL_W      (SEL_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .conv_en      (conv_en),
  .trig_mode_en (trig_mode_en),
  .src_sel      (src_sel),
  .data_wr      (data_wr),
  .timer_evt    (timer_evt),
  .pwm_evt      (pwm_evt),
  .start_o      (start_o)
);

// File: tb/dac_start_sel_tb.sv
module dac_start_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_en = 1'b0;
  logic       trig_mode_en = 1'b0;
  logic [2:0] src_sel = 3'd0;
  logic [1:0] ext_qual = 2'd0;
  logic       sw_trig_wr = 1'b0;
  logic       sw_trig_wdata = 1'b0;
  logic       sw_trig_rdata;
  logic       data_wr = 1'b0;
  logic       ext_pin = 1'b0;
  logic [3:0] timer_evt = 4'd0;
  logic [1:0] pwm_evt = 2'd0;
  logic       busy = 1'b0;
  logic       start_o;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  dac_start_sel dut_i (
    .clk(clk), .rst(rst), .conv_en(conv_en), .trig_mode_en(trig_mode_en),
    .src_sel(src_sel), .ext_qual(ext_qual), .sw_trig_wr(sw_trig_wr),
    .sw_trig_wdata(sw_trig_wdata), .sw_trig_rdata(sw_trig_rdata),
    .data_wr(data_wr), .ext_pin(ext_pin), .timer_evt(timer_evt),
    .pwm_evt(pwm_evt), .busy(busy), .start_o(start_o)
  );

  // Behavioural reference: pin sample history, software pulse, expected start.
  bit m_sw, m_start;
  bit pin_hist[$];

  function automatic bit ref_cand();
    bit now_s, old_s;
    now_s = pin_hist[1];
    old_s = pin_hist[2];
    if (!trig_mode_en) return data_wr;
    case (src_sel)
      3'd0: return m_sw;
      3'd1: begin
        case (ext_qual)
          2'd0: return !now_s && !busy;
          2'd1: return now_s && !busy;
          2'd2: return !now_s && old_s;
          default: return now_s && !old_s;
        endcase
      end
      3'd6: return pwm_evt[0];
      3'd7: return pwm_evt[1];
      default: return timer_evt[int'(src_sel) - 2];
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sw    <= 1'b0;
      m_start <= 1'b0;
      pin_hist = '{0, 0, 0};
    end else begin
      m_start <= conv_en && ref_cand() && !m_start;
      m_sw    <= sw_trig_wr && sw_trig_wdata;
      pin_hist.push_front(ext_pin);
      void'(pin_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (start_o !== m_start) begin
        errors++;
        $display("FAIL %s: start_o actual=%0b expected=%0b at %0t", cur_req, start_o, m_start, $time);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    idle(4);
    chk(start_o, 1'b0, "R1");
    chk(sw_trig_rdata, 1'b0, "R1");
    rst = 1'b0;
    conv_en = 1'b1;
    idle(2);

    // R2: direct data write start; trigger sources ignored
    cur_req = "R2";
    data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
    chk(start_o, 1'b1, "R2");
    idle(2);
    timer_evt = 4'hF; pwm_evt = 2'b11;
    @(negedge clk); timer_evt = 4'h0; pwm_evt = 2'b00;
    chk(start_o, 1'b0, "R2");
    idle(2);

    // R3: data writes ignored in trigger mode
    cur_req = "R3";
    trig_mode_en = 1'b1; src_sel = 3'd2;
    idle(1);
    data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
    chk(start_o, 1'b0, "R3");
    idle(2);

    // R4: each timer / pwm code, plus unselected lines
    cur_req = "R4";
    for (int s = 2; s < 8; s++) begin
      src_sel = 3'(s);
      idle(1);
      if (s < 6) timer_evt[s-2] = 1'b1; else pwm_evt[s-6] = 1'b1;
      @(negedge clk); timer_evt = 4'h0; pwm_evt = 2'b00;
      chk(start_o, 1'b1, "R4");
      idle(1);
      timer_evt = (s < 6) ? ~(4'b1 << (s-2)) : 4'hF;
      pwm_evt   = (s < 6) ? 2'b11 : ~(2'b1 << (s-6));
      @(negedge clk); timer_evt = 4'h0; pwm_evt = 2'b00;
      chk(start_o, 1'b0, "R4");
      idle(1);
    end

    // R5: self-clearing software bit
    cur_req = "R5";
    src_sel = 3'd0;
    idle(1);
    sw_trig_wr = 1'b1; sw_trig_wdata = 1'b1;
    @(negedge clk); sw_trig_wr = 1'b0; sw_trig_wdata = 1'b0;
    chk(start_o, 1'b0, "R5");
    chk(sw_trig_rdata, 1'b0, "R5");
    @(negedge clk);
    chk(start_o, 1'b1, "R5");
    @(negedge clk);
    chk(start_o, 1'b0, "R5");
    sw_trig_wr = 1'b1; sw_trig_wdata = 1'b0;
    @(negedge clk); sw_trig_wr = 1'b0;
    idle(1);
    chk(start_o, 1'b0, "R5");

    // R6: external pin qualifications through the synchronizer
    cur_req = "R6";
    src_sel = 3'd1; ext_qual = 2'd3; ext_pin = 1'b0;
    idle(4);
    ext_pin = 1'b1;
    idle(2);
    chk(start_o, 1'b0, "R6");
    idle(1);
    chk(start_o, 1'b1, "R6");
    idle(3);
    ext_qual = 2'd2;
    idle(1);
    ext_pin = 1'b0;
    idle(3);
    chk(start_o, 1'b1, "R6");
    idle(3);

    // R7: level modes blocked while busy
    cur_req = "R7";
    busy = 1'b1; ext_qual = 2'd0;
    idle(4);
    chk(start_o, 1'b0, "R7");
    ext_qual = 2'd1; ext_pin = 1'b1;
    idle(5);
    chk(start_o, 1'b0, "R7");
    busy = 1'b0;
    idle(1);
    chk(start_o, 1'b1, "R7");
    busy = 1'b1;
    idle(2);

    // R8: held source gives separated single pulses
    cur_req = "R8";
    busy = 1'b0; ext_pin = 1'b0; src_sel = 3'd6;
    idle(4);
    pwm_evt[0] = 1'b1;
    idle(1);
    chk(start_o, 1'b1, "R8");
    idle(1);
    chk(start_o, 1'b0, "R8");
    idle(4);
    pwm_evt[0] = 1'b0;
    idle(2);

    // R9: converter disabled suppresses starts
    cur_req = "R9";
    conv_en = 1'b0; src_sel = 3'd3;
    timer_evt[1] = 1'b1;
    idle(1);
    chk(start_o, 1'b0, "R9");
    timer_evt = 4'h0; trig_mode_en = 1'b0; data_wr = 1'b1;
    idle(1);
    chk(start_o, 1'b0, "R9");
    data_wr = 1'b0; conv_en = 1'b1; trig_mode_en = 1'b1;
    idle(2);

    // Mixed stimulus checked against the reference every clock (R4 R6 R7 R8)
    cur_req = "R4/R6 mixed";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(15) == 0) src_sel = 3'($urandom_range(7));
      if ($urandom_range(31) == 0) ext_qual = 2'($urandom_range(3));
      if ($urandom_range(7) == 0) ext_pin = ~ext_pin;
      if ($urandom_range(31) == 0) trig_mode_en = ~trig_mode_en;
      conv_en       = ($urandom_range(15) != 0);
      busy          = ($urandom_range(3) == 0);
      data_wr       = ($urandom_range(7) == 0);
      sw_trig_wr    = ($urandom_range(7) == 0);
      sw_trig_wdata = 1'($urandom_range(1));
      timer_evt     = 4'($urandom_range(15)) & 4'($urandom_range(15));
      pwm_evt       = 2'($urandom_range(3)) & 2'($urandom_range(3));
      @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule